// File: doc/BRIEF.md
# Ethernet Station Address Filter and Source Inserter

This block sits beside an Ethernet MAC datapath. It holds two 48-bit addresses: the station's own source address and a destination address to match against. Each is kept as a pair of 24-bit words, with the first three bytes on the wire in the upper word and the last three in the lower word. A small register port programs both addresses and a control word.

On the receive side, the block watches the first six bytes of each frame, which form the destination address. It raises a per-frame verdict flag. Two enable bits in the control word select one of three outcomes: every frame passes, every frame fails, or the verdict is a true comparison against the stored match address. On the transmit side, the block passes the byte stream through one register stage. When insertion is enabled, it overwrites the six source-address bytes with the stored station address.

Each path takes its configuration as a snapshot at its own start-of-frame. A write made while a frame is in flight therefore affects only later frames.

Top module: `mac_addr_filter_ins`

## Requirements
- R1: Register offsets: 0 is control, 1 is the source lower word, 2 is the source upper word, 3 is the match lower word, 4 is the match upper word. Address words occupy data bits [23:0], and bits above 23 read as zero. The upper word holds the first three bytes on the wire, most significant byte first, so address 00-07-ED-11-22-33 is upper 0x0007ED and lower 0x112233.
- R2: After reset, control reads 0, the source lower word reads 0x00FF1234, the source upper word reads 0x0007ED, and both match words read 0. Neither output valid flag is set.
- R3: In the control word, bit 31 is the insert enable, bit 30 is the filter enable and bit 0 is the compare enable. All three are read/write. Bits 29 to 1 always read as zero, whatever was written.
- R4: With bit 30 clear, every received frame's verdict is match (1), whatever bit 0 holds.
- R5: With bit 30 set and bit 0 clear, every received frame's verdict is no-match (0).
- R6: With bits 30 and 0 both set, the verdict is 1 exactly when the six destination bytes equal the stored match address in wire order.
- R7: `rx_match_vld` rises in the cycle after the sixth accepted byte of a frame, counting the start-of-frame byte as the first. Idle cycles in between do not count. The flag and the verdict hold until the next accepted start-of-frame byte, and the flag is low from the cycle after that byte.
- R8: The transmit output repeats `tx_in_valid`, `tx_in_sof` and `tx_in_byte` one cycle later. With insert disabled, every byte passes unchanged.
- R9: With insert enabled, the frame bytes at indices 6 to 11 (index 0 is the start-of-frame byte) are replaced in order by the upper word, most significant byte first, then the lower word, most significant byte first. All other bytes pass unchanged.
- R10: Each path samples the control bits and its address at its accepted start-of-frame byte. A register write made in that same cycle or later within the frame applies only from the next frame.
- R11: Reads of offsets 5 and above return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| rx_sof | input | 1 | Marks the first destination byte of a received frame |
| rx_valid | input | 1 | Receive byte qualifier |
| rx_byte | input | 8 | Receive header byte |
| rx_match | output | 1 | Destination verdict of the current frame |
| rx_match_vld | output | 1 | Verdict valid |
| tx_in_sof | input | 1 | First byte of a frame to transmit |
| tx_in_valid | input | 1 | Transmit input byte qualifier |
| tx_in_byte | input | 8 | Transmit input byte |
| tx_out_sof | output | 1 | Start-of-frame, delayed one cycle |
| tx_out_valid | output | 1 | Output byte qualifier |
| tx_out_byte | output | 8 | Output byte, with source bytes substituted when enabled |

## Verification
A wrong receive byte counter shows up at the ports as `rx_match_vld` rising one cycle early or late after the sixth byte, or as a verdict computed against the wrong byte. The bench sees this in the cycle right after the sixth byte. A wrong transmit index or snapshot moves or corrupts the substituted bytes, and the fault shows at `tx_out_byte` one cycle after the affected input byte. A snapshot taken at the wrong time only becomes visible on the frame that follows a mid-frame write, so the bench writes at the start-of-frame byte and inside frames, then sends a second frame.

// File: rtl/maf_pkg.sv
package maf_pkg;

    // control word bit positions
    localparam int INS_BIT = 31;
    localparam int CHK_BIT = 30;
    localparam int CMP_BIT = 0;

    // register offsets
    localparam int OFS_CTRL   = 0;
    localparam int OFS_SRC_LO = 1;
    localparam int OFS_SRC_HI = 2;
    localparam int OFS_DST_LO = 3;
    localparam int OFS_DST_HI = 4;
    localparam int NUM_REGS   = 5;

    typedef struct packed {
        logic ins_en;
        logic chk_en;
        logic cmp_en;
    } cfg_t;

    // three-way destination verdict
    function automatic logic verdict(cfg_t c, logic eq);
        if (!c.chk_en) return 1'b1;
        if (!c.cmp_en) return 1'b0;
        return eq;
    endfunction

endpackage

// File: rtl/maf_regs.sv
module maf_regs
    import maf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int WORD_W = 24,
    parameter logic [WORD_W-1:0] SRC_LO_RST = 24'hFF1234,
    parameter logic [WORD_W-1:0] SRC_HI_RST = 24'h0007ED,
    parameter logic [WORD_W-1:0] DST_LO_RST = '0,
    parameter logic [WORD_W-1:0] DST_HI_RST = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output cfg_t                cfg,
    output logic [2*WORD_W-1:0] src_addr,
    output logic [2*WORD_W-1:0] dst_addr
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_SLO  = ADDR_W'(OFS_SRC_LO);
    localparam logic [ADDR_W-1:0] A_SHI  = ADDR_W'(OFS_SRC_HI);
    localparam logic [ADDR_W-1:0] A_DLO  = ADDR_W'(OFS_DST_LO);
    localparam logic [ADDR_W-1:0] A_DHI  = ADDR_W'(OFS_DST_HI);
    localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(NUM_REGS);
    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'(1) << INS_BIT) | (DATA_W'(1) << CHK_BIT) | (DATA_W'(1) << CMP_BIT);

    typedef struct packed {
        cfg_t              cfg;
        logic [WORD_W-1:0] src_lo;
        logic [WORD_W-1:0] src_hi;
        logic [WORD_W-1:0] dst_lo;
        logic [WORD_W-1:0] dst_hi;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^wdata;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    st_d.cfg.ins_en = wdata[INS_BIT];
                    st_d.cfg.chk_en = wdata[CHK_BIT];
                    st_d.cfg.cmp_en = wdata[CMP_BIT];
                end
                A_SLO:   st_d.src_lo = wdata[WORD_W-1:0];
                A_SHI:   st_d.src_hi = wdata[WORD_W-1:0];
                A_DLO:   st_d.dst_lo = wdata[WORD_W-1:0];
                A_DHI:   st_d.dst_hi = wdata[WORD_W-1:0];
                default: st_d = st_q;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[INS_BIT] = st_q.cfg.ins_en;
                rdata[CHK_BIT] = st_q.cfg.chk_en;
                rdata[CMP_BIT] = st_q.cfg.cmp_en;
            end
            A_SLO:   rdata[WORD_W-1:0] = st_q.src_lo;
            A_SHI:   rdata[WORD_W-1:0] = st_q.src_hi;
            A_DLO:   rdata[WORD_W-1:0] = st_q.dst_lo;
            A_DHI:   rdata[WORD_W-1:0] = st_q.dst_hi;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: '0, src_lo: SRC_LO_RST, src_hi: SRC_HI_RST,
                      dst_lo: DST_LO_RST, dst_hi: DST_HI_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg      = st_q.cfg;
    assign src_addr = {st_q.src_hi, st_q.src_lo};
    assign dst_addr = {st_q.dst_hi, st_q.dst_lo};

    // R3
    ctrl_resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTRL) |-> ((rdata & ~CTRL_MASK) == '0));

    // R11
    unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= A_END) |-> (rdata == '0));

    // R11
    unmapped_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= A_END) |=> ($stable(cfg) && $stable(src_addr) && $stable(dst_addr)));

endmodule

// File: rtl/maf_rx_match.sv
module maf_rx_match
    import maf_pkg::*;
#(
    parameter int MAC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_sof,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  cfg_t             cfg,
    input  logic [MAC_W-1:0] dst_addr,
    output logic             match,
    output logic             match_vld
);

    localparam int NB    = MAC_W / 8;
    localparam int CNT_W = $clog2(NB + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             eq;
        cfg_t             cfg;
        logic [MAC_W-1:0] dst;
        logic             vld;
        logic             match;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   sof_now;
    logic   eq_n;

    function automatic logic [7:0] pick(logic [MAC_W-1:0] a, int i);
        return 8'(a >> (8 * (NB - 1 - i)));
    endfunction

    assign sof_now = rx_valid && rx_sof;

    always_comb begin
        st_d = st_q;
        eq_n = 1'b0;
        if (sof_now) begin
            st_d.cfg   = cfg;
            st_d.dst   = dst_addr;
            st_d.eq    = (rx_byte == pick(dst_addr, 0));
            st_d.cnt   = CNT_W'(1);
            st_d.vld   = 1'b0;
            st_d.match = 1'b0;
        end else if (rx_valid && st_q.cnt != '0 && st_q.cnt < CNT_W'(NB)) begin
            eq_n       = st_q.eq && (rx_byte == pick(st_q.dst, int'(st_q.cnt)));
            st_d.eq    = eq_n;
            st_d.cnt   = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(NB - 1)) begin
                st_d.vld   = 1'b1;
                st_d.match = verdict(st_q.cfg, eq_n);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match     = st_q.match;
    assign match_vld = st_q.vld;

    // R7
    vld_clear_on_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_now |=> !match_vld);

    // R7
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vld && !sof_now) |=> (match_vld && $stable(match)));

    // R4
    filter_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(match_vld) && !st_q.cfg.chk_en) |-> match);

    // R10
    rx_snapshot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_now |=> ($stable(st_q.cfg) && $stable(st_q.dst)));

endmodule

// File: rtl/maf_tx_insert.sv
module maf_tx_insert
    import maf_pkg::*;
#(
    parameter int MAC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_sof,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  cfg_t             cfg,
    input  logic [MAC_W-1:0] src_addr,
    output logic             out_sof,
    output logic             out_valid,
    output logic [7:0]       out_byte
);

    localparam int NB  = MAC_W / 8;
    localparam int LIM = 2 * NB;
    localparam int IW  = $clog2(LIM + 1);

    typedef struct packed {
        logic [IW-1:0]    idx;
        logic             ins;
        logic [MAC_W-1:0] src;
        logic             ov;
        logic             os;
        logic [7:0]       ob;
    } tx_st_t;

    tx_st_t           st_d, st_q;
    logic             sof_now;
    logic [IW-1:0]    cur_idx;
    logic             cur_ins;
    logic [MAC_W-1:0] cur_src;
    logic             in_window;

    function automatic logic [7:0] pick(logic [MAC_W-1:0] a, int i);
        return 8'(a >> (8 * (NB - 1 - i)));
    endfunction

    assign sof_now   = in_valid && in_sof;
    assign cur_idx   = sof_now ? '0 : st_q.idx;
    assign cur_ins   = sof_now ? cfg.ins_en : st_q.ins;
    assign cur_src   = sof_now ? src_addr : st_q.src;
    assign in_window = (cur_idx >= IW'(NB)) && (cur_idx < IW'(LIM));

    always_comb begin
        st_d    = st_q;
        st_d.ov = in_valid;
        st_d.os = sof_now;
        st_d.ob = in_byte;
        if (in_valid) begin
            st_d.ins = cur_ins;
            st_d.src = cur_src;
            if (cur_idx < IW'(LIM)) begin
                st_d.idx = cur_idx + 1'b1;
            end
            if (cur_ins && in_window) begin
                st_d.ob = pick(cur_src, int'(cur_idx) - NB);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.idx <= IW'(LIM);
        end else begin
            st_q <= st_d;
        end
    end

    assign out_sof   = st_q.os;
    assign out_valid = st_q.ov;
    assign out_byte  = st_q.ob;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cur_ins) |=> (out_byte == $past(in_byte)));

    // R10
    tx_snapshot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_now |=> ($stable(st_q.src) && $stable(st_q.ins)));

endmodule

// File: rtl/mac_addr_filter_ins.sv
module mac_addr_filter_ins
    import maf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_match,
    output logic              rx_match_vld,
    input  logic              tx_in_sof,
    input  logic              tx_in_valid,
    input  logic [7:0]        tx_in_byte,
    output logic              tx_out_sof,
    output logic              tx_out_valid,
    output logic [7:0]        tx_out_byte
);

    localparam int MAC_W = 2 * WORD_W;

    cfg_t             cfg;
    logic [MAC_W-1:0] src_addr;
    logic [MAC_W-1:0] dst_addr;

    maf_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cfg      (cfg),
        .src_addr (src_addr),
        .dst_addr (dst_addr)
    );

    maf_rx_match #(
        .MAC_W (MAC_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_sof    (rx_sof),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .cfg       (cfg),
        .dst_addr  (dst_addr),
        .match     (rx_match),
        .match_vld (rx_match_vld)
    );

    maf_tx_insert #(
        .MAC_W (MAC_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_sof    (tx_in_sof),
        .in_valid  (tx_in_valid),
        .in_byte   (tx_in_byte),
        .cfg       (cfg),
        .src_addr  (src_addr),
        .out_sof   (tx_out_sof),
        .out_valid (tx_out_valid),
        .out_byte  (tx_out_byte)
    );

endmodule

// File: tb/mac_addr_filter_ins_test.sv
`timescale 1ns/1ps
module mac_addr_filter_ins_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        rx_sof, rx_valid;
    logic [7:0]  rx_byte;
    logic        rx_match, rx_match_vld;
    logic        tx_in_sof, tx_in_valid;
    logic [7:0]  tx_in_byte;
    logic        tx_out_sof, tx_out_valid;
    logic [7:0]  tx_out_byte;

    int n_chk  = 0;
    int n_fail = 0;

    // bench model of programmed registers
    logic        m_ins, m_chk, m_cmp;
    logic [23:0] m_slo, m_shi, m_dlo, m_dhi;

    // expectation for the tx output in the next sample
    logic       p_v = 1'b0;
    logic       p_sof, p_ins;
    logic [7:0] p_byte;
    int         p_idx;

    always #4 clk = ~clk;

    mac_addr_filter_ins uut (
        .clk (clk), .rst_n (rst_n),
        .reg_wr_en (reg_wr_en), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .rx_sof (rx_sof), .rx_valid (rx_valid), .rx_byte (rx_byte),
        .rx_match (rx_match), .rx_match_vld (rx_match_vld),
        .tx_in_sof (tx_in_sof), .tx_in_valid (tx_in_valid), .tx_in_byte (tx_in_byte),
        .tx_out_sof (tx_out_sof), .tx_out_valid (tx_out_valid), .tx_out_byte (tx_out_byte)
    );

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'd0:    return {m_ins, m_chk, 29'b0, m_cmp};
            4'd1:    return {8'b0, m_slo};
            4'd2:    return {8'b0, m_shi};
            4'd3:    return {8'b0, m_dlo};
            4'd4:    return {8'b0, m_dhi};
            default: return 32'b0;
        endcase
    endfunction

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        case (a)
            4'd0: begin m_ins = d[31]; m_chk = d[30]; m_cmp = d[0]; end
            4'd1: m_slo = d[23:0];
            4'd2: m_shi = d[23:0];
            4'd3: m_dlo = d[23:0];
            4'd4: m_dhi = d[23:0];
            default: ;
        endcase
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        model_write(a, d);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input string req);
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = a;
        #1;
        check(reg_rdata == exp_rd(a), req, reg_rdata, exp_rd(a));
    endtask

    // receive side sample: done = bytes driven so far in this frame
    task automatic rx_chk(input int done, input logic exp_m, input string tag);
        check(rx_match_vld == (done >= 6), "R7", rx_match_vld, done >= 6);
        if (done >= 6) check(rx_match == exp_m, tag, rx_match, exp_m);
    endtask

    task automatic rx_frame(input logic [47:0] da, input int len, input int wr_at,
                            input logic [3:0] wa, input logic [31:0] wd, input bit gaps);
        logic  exp_m;
        string tag;
        int    done;
        done  = 0;
        exp_m = 1'b0;
        tag   = "R7";
        for (int i = 0; i < len; i++) begin
            if (gaps && i > 0 && ($urandom % 4) == 0) begin
                @(negedge clk);
                rx_chk(done, exp_m, tag);
                rx_valid = 1'b0; rx_sof = 1'b0; reg_wr_en = 1'b0;
            end
            @(negedge clk);
            if (i > 0) rx_chk(done, exp_m, tag);
            if (i == 0) begin
                // snapshot of programmed state before any same-cycle write (R10)
                exp_m = !m_chk ? 1'b1 : (m_cmp ? (da == {m_dhi, m_dlo}) : 1'b0);
                tag   = !m_chk ? "R4" : (m_cmp ? "R6" : "R5");
            end
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_byte  = (i < 6) ? da[47 - 8*i -: 8] : 8'($urandom);
            if (i == wr_at) begin
                reg_wr_en = 1'b1; reg_addr = wa; reg_wdata = wd;
                model_write(wa, wd);
            end else begin
                reg_wr_en = 1'b0;
            end
            done++;
        end
        @(negedge clk);
        rx_chk(done, exp_m, tag);
        rx_valid = 1'b0; rx_sof = 1'b0; reg_wr_en = 1'b0;
        @(negedge clk);
        rx_chk(done, exp_m, tag);
    endtask

    task automatic tx_chk;
        check(tx_out_valid == p_v, "R8", tx_out_valid, p_v);
        if (p_v) begin
            check(tx_out_sof == p_sof, "R8", tx_out_sof, p_sof);
            if (p_ins && p_idx >= 6 && p_idx < 12)
                check(tx_out_byte == p_byte, "R9", tx_out_byte, p_byte);
            else
                check(tx_out_byte == p_byte, "R8", tx_out_byte, p_byte);
        end
    endtask

    task automatic tx_frame(input int len, input int wr_at, input logic [3:0] wa,
                            input logic [31:0] wd, input bit gaps);
        logic        s_ins;
        logic [47:0] s_src;
        logic [7:0]  b;
        s_ins = 1'b0;
        s_src = '0;
        for (int i = 0; i < len; i++) begin
            if (gaps && i > 0 && ($urandom % 3) == 0) begin
                @(negedge clk);
                tx_chk();
                tx_in_valid = 1'b0; tx_in_sof = 1'b0; reg_wr_en = 1'b0;
                p_v = 1'b0;
            end
            @(negedge clk);
            tx_chk();
            if (i == 0) begin
                s_ins = m_ins;
                s_src = {m_shi, m_slo};
            end
            b = 8'($urandom);
            tx_in_valid = 1'b1; tx_in_sof = (i == 0); tx_in_byte = b;
            p_v = 1'b1; p_sof = (i == 0); p_idx = i; p_ins = s_ins;
            p_byte = (s_ins && i >= 6 && i < 12) ? s_src[47 - 8*(i-6) -: 8] : b;
            if (i == wr_at) begin
                reg_wr_en = 1'b1; reg_addr = wa; reg_wdata = wd;
                model_write(wa, wd);
            end else begin
                reg_wr_en = 1'b0;
            end
        end
        @(negedge clk);
        tx_chk();
        tx_in_valid = 1'b0; tx_in_sof = 1'b0; reg_wr_en = 1'b0;
        p_v = 1'b0;
        @(negedge clk);
        tx_chk();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [47:0] da;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        rx_sof = 1'b0; rx_valid = 1'b0; rx_byte = '0;
        tx_in_sof = 1'b0; tx_in_valid = 1'b0; tx_in_byte = '0;
        m_ins = 1'b0; m_chk = 1'b0; m_cmp = 1'b0;
        m_slo = 24'hFF1234; m_shi = 24'h0007ED; m_dlo = '0; m_dhi = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        for (int a = 0; a < 5; a++) rd_chk(4'(a), "R2");
        check(rx_match_vld == 1'b0, "R2", rx_match_vld, 0);
        check(tx_out_valid == 1'b0, "R2", tx_out_valid, 0);

        // R11: unmapped reads and ignored writes
        rd_chk(4'd5, "R11");
        rd_chk(4'd15, "R11");
        reg_write(4'd5, 32'hFFFF_FFFF);
        reg_write(4'd15, 32'h1234_5678);
        for (int a = 0; a < 8; a++) rd_chk(4'(a), "R11");

        // R3: reserved control bits read zero
        reg_write(4'd0, 32'hFFFF_FFFF);
        rd_chk(4'd0, "R3");
        check(reg_rdata == 32'hC000_0001, "R3", reg_rdata, 32'hC000_0001);
        reg_write(4'd0, 32'h0000_0000);
        rd_chk(4'd0, "R3");

        // R1: word layout, upper bits dropped
        reg_write(4'd2, 32'hAB00_07ED);
        reg_write(4'd1, 32'hCD11_2233);
        rd_chk(4'd2, "R1");
        rd_chk(4'd1, "R1");
        reg_write(4'd4, 32'h0000_0A0B);
        reg_write(4'd3, 32'h000C_0D0E);
        rd_chk(4'd4, "R1");
        rd_chk(4'd3, "R1");

        // R4: filter disabled, compare bit ignored
        rx_frame(48'h1122_3344_5566, 8, -1, 4'd0, 0, 1'b0);
        reg_write(4'd0, 32'h0000_0001);
        rx_frame(48'h0000_0A0B_0C0D, 7, -1, 4'd0, 0, 1'b1);
        // R5: filter on, compare off: even the stored address fails
        reg_write(4'd0, 32'h4000_0000);
        rx_frame(48'h000A_0B0C_0D0E, 9, -1, 4'd0, 0, 1'b0);
        // R6: real compare, equal and differing in first / last byte
        reg_write(4'd0, 32'h4000_0001);
        rx_frame(48'h000A_0B0C_0D0E, 6, -1, 4'd0, 0, 1'b0);
        rx_frame(48'h800A_0B0C_0D0E, 10, -1, 4'd0, 0, 1'b1);
        rx_frame(48'h000A_0B0C_0D0F, 8, -1, 4'd0, 0, 1'b1);
        // R7: short frame never raises the flag
        rx_frame(48'h000A_0B0C_0D0E, 4, -1, 4'd0, 0, 1'b0);

        // R10: mid-frame control write affects next frame only
        rx_frame(48'h000A_0B0C_0D0E, 9, 2, 4'd0, 32'h4000_0000, 1'b0);
        check(rx_match == 1'b1, "R10", rx_match, 1);
        rx_frame(48'h000A_0B0C_0D0E, 8, -1, 4'd0, 0, 1'b0);
        check(rx_match == 1'b0, "R10", rx_match, 0);
        // R10: write in the start-of-frame cycle
        reg_write(4'd0, 32'h4000_0001);
        rx_frame(48'h000A_0B0C_0D0E, 8, 0, 4'd3, 32'h0000_0000, 1'b0);
        check(rx_match == 1'b1, "R10", rx_match, 1);

        // random receive frames
        for (int k = 0; k < 30; k++) begin
            reg_write(4'd0, {$urandom % 2 == 0, $urandom % 4 != 0, 29'b0, $urandom % 4 != 0});
            da = {$urandom, $urandom};
            if ($urandom % 2 == 0) da = {m_dhi, m_dlo} ^ (($urandom % 3 == 0) ? 48'h1 << ($urandom % 48) : 48'h0);
            rx_frame(da, 6 + $urandom % 8, ($urandom % 2 == 0) ? int'($urandom % 6) : -1,
                     4'(3 + $urandom % 2), {8'b0, 24'($urandom)}, 1'b1);
        end

        // R8: pass-through with insertion off
        reg_write(4'd0, 32'h0000_0000);
        tx_frame(16, -1, 4'd0, 0, 1'b0);
        // R9: insertion of 00-07-ED-11-22-33
        reg_write(4'd2, 32'h0000_07ED);
        reg_write(4'd1, 32'h0011_2233);
        reg_write(4'd0, 32'h8000_0000);
        tx_frame(20, -1, 4'd0, 0, 1'b0);
        tx_frame(18, -1, 4'd0, 0, 1'b1);
        // R9: short frame, partial window
        tx_frame(9, -1, 4'd0, 0, 1'b0);
        // R10: source write mid-frame and at start-of-frame
        tx_frame(16, 4, 4'd1, 32'h00AB_CDEF, 1'b0);
        tx_frame(16, 0, 4'd2, 32'h0055_6677, 1'b1);
        tx_frame(14, 7, 4'd0, 32'h0000_0000, 1'b0);
        tx_frame(14, -1, 4'd0, 0, 1'b0);

        // random transmit frames
        for (int k = 0; k < 30; k++) begin
            if ($urandom % 3 == 0) reg_write(4'd0, {$urandom % 2 == 0, 31'b0});
            tx_frame(1 + $urandom % 20, ($urandom % 2 == 0) ? int'($urandom % 12) : -1,
                     4'($urandom % 3), {$urandom}, 1'b1);
        end

        report();
        $finish;
    end

endmodule